// File: doc/BRIEF.md
# Buffered SPI Master

This block is a serial-peripheral-interface master that sits behind two eight-entry queues. Software-side logic pushes bytes into a transmit queue with a write strobe. The shift engine takes the oldest byte, clocks it out most significant bit first in clock mode 0, and collects the byte returned on the input line into a receive queue. A read strobe pops that receive queue. The serial clock rate comes from a primary and a secondary prescale factor. The engine latches the product of the two at the start of every byte.

The flags are exact. The transmit-full flag and the pending-entry count follow the real queue occupancy at every divider setting. A slot is freed only in the cycle its byte is moved into the shift register. A sleep input stops new bytes from starting. When sleep is released with nothing queued, no clock edge appears and nothing is added to the receive queue. Dropping the enable stops the engine at once and empties both queues.

The engine is a three-state machine:
- `S_IDLE`: the clock is low.
- `S_LOW`: the low half of a bit.
- `S_HIGH`: the high half of a bit.

Its transitions are:
- `S_IDLE` to `S_LOW` on a start. A start needs enable high, sleep low, a queued byte and room in the receive queue.
- `S_LOW` to `S_HIGH` when the half-period tick fires. The input bit is sampled here.
- `S_HIGH` to `S_LOW` on the tick when bits remain. The output shifts here.
- `S_HIGH` to `S_IDLE` on the tick of the eighth bit. The received byte is pushed here.
- Any state to `S_IDLE` while enable is low.

Top module: `spim_top`

## Requirements
- R1: After reset with enable low, the outputs read as follows: `sck`=0, `mosi`=0, `tx_full`=0, `rx_full`=0, `rx_avail`=0, `ovf`=0 and `elem_cnt`=0.
- R2: With `en`=1, a `wr_stb` pulse while `tx_full`=0 adds `wr_data` to the transmit queue. `elem_cnt` counts the bytes queued but not yet started, from 0 to 8, and changes by at most +1 per cycle.
- R3: `tx_full` is 1 exactly when 8 bytes are waiting. A write while `tx_full`=1 is dropped and sets `ovf`. `ovf` stays set until `en` goes low.
- R4: Each byte is sent as 8 bits, MSB first. `sck` idles low. `mosi` is valid before each rising edge of `sck`, and `miso` is sampled at that edge. `sck` is never high while the engine is idle.
- R5: Each half of an `sck` period lasts (sec_sel+1) x 4^pri_sel system clocks, with `pri_sel` 2 bits and `sec_sel` 3 bits.
- R6: A byte leaves the transmit queue in the cycle its transfer starts. In that cycle `elem_cnt` drops by one and `tx_full` clears, at any divider setting.
- R7: The received byte enters the receive queue when its last high half ends. `rd_data` shows the oldest entry and `rd_stb` removes it. `rx_avail`=1 when the queue is not empty, and `rx_full`=1 when it holds 8.
- R8: No transfer starts while `rx_full`=1. Queued bytes stay counted in `elem_cnt` and start after a read frees a slot.
- R9: While `sleep`=1 no new transfer starts, but a byte already in flight completes. Releasing `sleep` with an empty transmit queue produces no `sck` edge and no received byte.
- R10: With `en`=0 the engine returns to idle on the next clock, with `sck` low. Both queues empty, any partial byte is discarded, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable; low clears and stops everything |
| sleep | input | 1 | Core sleep request; blocks new transfers |
| pri_sel | input | 2 | Primary prescale select, factor 4^pri_sel |
| sec_sel | input | 3 | Secondary prescale select, factor sec_sel+1 |
| wr_stb | input | 1 | Write strobe for the transmit queue |
| wr_data | input | 8 | Byte to queue |
| rd_stb | input | 1 | Pop strobe for the receive queue |
| miso | input | 1 | Serial input from the slave |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial output to the slave |
| tx_full | output | 1 | Transmit queue holds 8 waiting bytes |
| rx_full | output | 1 | Receive queue holds 8 bytes |
| rx_avail | output | 1 | Receive queue not empty |
| elem_cnt | output | 4 | Bytes queued and not yet started |
| rd_data | output | 8 | Oldest received byte |
| ovf | output | 1 | Sticky write-overflow flag |

## Verification
A read pointer that advanced too early would first show at the ports as a wrong `mosi` byte. That byte appears one full byte time after the start. `elem_cnt` would also fall before any `sck` edge, so the bench compares it within a clock of the first rising edge, even with a 32-clock half period. A miscounted half-period counter shows as a wrong high-phase length on the first bit. A state machine that leaves idle on its own after sleep shows as an `sck` edge inside a quiet window that the bench counts.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } eng_st_e;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop  && (count != '0);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/spim_tick.sv
module spim_tick #(
    parameter int HW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] half,
    output logic          tick
);
    logic [HW-1:0] cnt;

    assign tick = run && (cnt == half - HW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                  cnt <= cnt + HW'(1);
    end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int W     = 8,
    parameter int PRI_W = 2,
    parameter int SEC_W = 3,
    parameter int HW    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sleep,
    input  logic [PRI_W-1:0] pri_sel,
    input  logic [SEC_W-1:0] sec_sel,
    input  logic             tx_ready,
    input  logic             rx_room,
    input  logic [W-1:0]     tx_head,
    input  logic             miso,
    input  logic             tick,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [W-1:0]     rx_byte,
    output logic             sck,
    output logic             mosi,
    output logic             run,
    output logic [HW-1:0]    half,
    output eng_st_e          st
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    eng_st_e       st_nx;
    logic [W-1:0]  shreg, rxsh;
    logic [BW-1:0] bitc;
    logic [HW-1:0] h_calc;
    logic          start, last;

    assign h_calc  = (HW'(sec_sel) + HW'(1)) << {pri_sel, 1'b0};
    assign start   = (st == S_IDLE) && en && !sleep && tx_ready && rx_room;
    assign last    = (bitc == BW'(W-1));
    assign rx_byte = rxsh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st <= S_IDLE;
        else if (!en) st <= S_IDLE;
        else          st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (start) st_nx = S_LOW;
            S_LOW:  if (tick)  st_nx = S_HIGH;
            S_HIGH: if (tick)  st_nx = last ? S_IDLE : S_LOW;
            default:           st_nx = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            rxsh  <= '0;
            bitc  <= '0;
            half  <= HW'(1);
        end else if (!en) begin
            shreg <= '0;
            rxsh  <= '0;
            bitc  <= '0;
        end else begin
            if (start) begin
                shreg <= tx_head;
                rxsh  <= '0;
                bitc  <= '0;
                half  <= h_calc;
            end else if (st == S_LOW && tick) begin
                rxsh <= {rxsh[W-2:0], miso};
            end else if (st == S_HIGH && tick && !last) begin
                shreg <= {shreg[W-2:0], 1'b0};
                bitc  <= bitc + BW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        sck     = (st == S_HIGH);
        run     = (st != S_IDLE);
        mosi    = shreg[W-1];
        tx_pop  = start;
        rx_push = en && (st == S_HIGH) && tick && last;
    end
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int PRI_W = 2,
    parameter int SEC_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       sleep,
    input  logic [PRI_W-1:0]           pri_sel,
    input  logic [SEC_W-1:0]           sec_sel,
    input  logic                       wr_stb,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_stb,
    input  logic                       miso,
    output logic                       sck,
    output logic                       mosi,
    output logic                       tx_full,
    output logic                       rx_full,
    output logic                       rx_avail,
    output logic [$clog2(DEPTH+1)-1:0] elem_cnt,
    output logic [W-1:0]               rd_data,
    output logic                       ovf
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int HW = 2 * ((1 << PRI_W) - 1) + SEC_W + 1;

    logic          tx_push, tx_pop, rx_push, rx_pop, run, tick;
    logic [W-1:0]  tx_head, rx_byte;
    logic [CW-1:0] rx_cnt;
    logic [HW-1:0] half;
    eng_st_e       eng_st;

    assign tx_full  = (elem_cnt == CW'(DEPTH));
    assign rx_full  = (rx_cnt == CW'(DEPTH));
    assign rx_avail = (rx_cnt != '0);
    assign tx_push  = en && wr_stb && !tx_full;
    assign rx_pop   = en && rd_stb && rx_avail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ovf <= 1'b0;
        else if (!en)                 ovf <= 1'b0;
        else if (wr_stb && tx_full)   ovf <= 1'b1;
    end

    spim_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(!en),
        .push(tx_push), .din(wr_data), .pop(tx_pop),
        .dout(tx_head), .count(elem_cnt)
    );

    spim_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(!en),
        .push(rx_push), .din(rx_byte), .pop(rx_pop),
        .dout(rd_data), .count(rx_cnt)
    );

    spim_tick #(.HW(HW)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .half(half), .tick(tick)
    );

    spim_engine #(.W(W), .PRI_W(PRI_W), .SEC_W(SEC_W), .HW(HW)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(en), .sleep(sleep),
        .pri_sel(pri_sel), .sec_sel(sec_sel),
        .tx_ready(elem_cnt != '0), .rx_room(!rx_full),
        .tx_head(tx_head), .miso(miso), .tick(tick),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
        .sck(sck), .mosi(mosi), .run(run), .half(half), .st(eng_st)
    );
endmodule

// File: rtl/spim_chk.sv
module spim_chk
    import spim_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       en,
    input logic                       sleep,
    input logic                       wr_stb,
    input logic                       sck,
    input logic                       tx_full,
    input logic                       rx_full,
    input logic                       ovf,
    input logic [$clog2(DEPTH+1)-1:0] elem_cnt,
    input eng_st_e                    st
);
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (!en || (int'(elem_cnt) <= int'($past(elem_cnt)) + 1)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_stb && tx_full) |=> ovf);

    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sleep && tx_full) |=> tx_full);

    p_idle_sck_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !sck);

    p_start_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && en && !sleep && !rx_full && elem_cnt != '0)
        |=> (st == S_LOW && !tx_full));

    p_rx_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_full && st == S_IDLE) |=> (st == S_IDLE));

    p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sleep && st == S_IDLE) |=> (st == S_IDLE));

    p_disable_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sck && elem_cnt == '0 && !rx_full && !ovf));
endmodule

bind spim_top spim_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .sleep(sleep), .wr_stb(wr_stb),
    .sck(sck), .tx_full(tx_full), .rx_full(rx_full), .ovf(ovf),
    .elem_cnt(elem_cnt), .st(eng_st)
);

// File: tb/test_spim_top.sv
`timescale 1ns/1ps
module test_spim_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       en = 1'b0, sleep = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, miso = 1'b0;
    logic [1:0] pri_sel = '0;
    logic [2:0] sec_sel = '0;
    logic [7:0] wr_data = '0;
    logic       sck, mosi, tx_full, rx_full, rx_avail, ovf;
    logic [3:0] elem_cnt;
    logic [7:0] rd_data;

    spim_top i_spim_top (
        .clk(clk), .rst_n(rst_n), .en(en), .sleep(sleep),
        .pri_sel(pri_sel), .sec_sel(sec_sel), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .miso(miso), .sck(sck), .mosi(mosi), .tx_full(tx_full),
        .rx_full(rx_full), .rx_avail(rx_avail), .elem_cnt(elem_cnt),
        .rd_data(rd_data), .ovf(ovf)
    );

    int total = 0, bad = 0, hp = 1;
    int mon_idx = 0, rises = 0, hi_run = 0, last_hi = 0;
    logic [7:0] mon_sh = '0;
    logic [7:0] exp_tx[$], exp_rx[$], slv_q[$];
    bit done = 0;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: collects mosi bytes at rising sck and scores them (R4)
    always @(posedge sck) begin
        rises++;
        mon_sh = {mon_sh[6:0], mosi};
        mon_idx++;
        if (mon_idx == 8) begin
            mon_idx = 0;
            if (exp_tx.size() == 0) begin
                total++; bad++;
                $display("FAIL R4 unexpected byte: actual=%0d expected=none", mon_sh);
            end else begin
                chk("R4", "mosi byte", int'(mon_sh), int'(exp_tx.pop_front()));
            end
            if (slv_q.size() != 0) void'(slv_q.pop_front());
        end
    end

    // slave response and high-phase length measurement
    always @(negedge clk) begin
        miso = (slv_q.size() != 0) ? slv_q[0][7-mon_idx] : 1'b0;
        if (sck) hi_run++;
        else if (hi_run != 0) begin
            last_hi = hi_run;
            hi_run  = 0;
        end
    end

    task automatic set_div(int p, int s);
        pri_sel = 2'(p);
        sec_sel = 3'(s);
        hp = (s + 1) << (2 * p);
    endtask

    task automatic put(logic [7:0] d, bit acc);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = d;
        if (acc) begin
            exp_tx.push_back(d);
            slv_q.push_back(d ^ 8'h5A);
            exp_rx.push_back(d ^ 8'h5A);
        end
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic take(string req);
        int e;
        @(negedge clk);
        e = (exp_rx.size() != 0) ? int'(exp_rx.pop_front()) : -1;
        chk(req, "rx_avail", int'(rx_avail), 1);
        chk(req, "rd_data", int'(rd_data), e);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic drain();
        while (exp_tx.size() != 0) @(negedge clk);
        repeat (2 * hp + 4) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "sck", int'(sck), 0);
        chk("R1", "mosi", int'(mosi), 0);
        chk("R1", "tx_full", int'(tx_full), 0);
        chk("R1", "rx_full", int'(rx_full), 0);
        chk("R1", "rx_avail", int'(rx_avail), 0);
        chk("R1", "ovf", int'(ovf), 0);
        chk("R1", "elem_cnt", int'(elem_cnt), 0);

        // R4/R7 basic traffic
        en = 1'b1;
        set_div(0, 1);
        put(8'hA5, 1); put(8'h3C, 1); put(8'h01, 1);
        drain();
        chk("R2", "elem_cnt drained", int'(elem_cnt), 0);
        take("R7"); take("R7"); take("R7");
        chk("R7", "rx_avail empty", int'(rx_avail), 0);

        // R5 half period
        set_div(1, 3);
        put(8'hC6, 1);
        drain();
        chk("R5", "high half 4x4", last_hi, 16);
        take("R7");
        set_div(0, 0);
        put(8'h81, 1);
        drain();
        chk("R5", "high half 1x1", last_hi, 1);
        take("R7");

        // R2/R3 fill while asleep, overflow
        sleep = 1'b1;
        set_div(2, 1);
        for (int i = 0; i < 8; i++) put(8'(8'h10 + i), 1);
        chk("R2", "elem_cnt full", int'(elem_cnt), 8);
        chk("R3", "tx_full", int'(tx_full), 1);
        chk("R3", "ovf before", int'(ovf), 0);
        put(8'hEE, 0);
        chk("R3", "ovf after", int'(ovf), 1);
        chk("R3", "elem_cnt unchanged", int'(elem_cnt), 8);

        // R6 slow divider: slot frees at start
        sleep = 1'b0;
        @(posedge sck);
        @(negedge clk);
        chk("R6", "elem_cnt after start", int'(elem_cnt), 7);
        chk("R6", "tx_full after start", int'(tx_full), 0);
        put(8'h77, 1);
        chk("R6", "tx_full refilled", int'(tx_full), 1);

        // R8 receive queue full blocks starts
        wait (rx_full == 1'b1);
        @(negedge clk);
        r = rises;
        repeat (300) @(negedge clk);
        chk("R8", "elem_cnt held", int'(elem_cnt), 1);
        chk("R8", "rx_full", int'(rx_full), 1);
        chk("R8", "sck edges while full", rises - r, 0);
        for (int i = 0; i < 8; i++) take("R7");
        drain();
        take("R8");

        // R9 wake with empty queue
        set_div(0, 1);
        sleep = 1'b1;
        repeat (20) @(negedge clk);
        r = rises;
        sleep = 1'b0;
        repeat (200) @(negedge clk);
        chk("R9", "sck edges after wake", rises - r, 0);
        chk("R9", "rx_avail after wake", int'(rx_avail), 0);

        // R9 sleep during a byte
        put(8'h5F, 1); put(8'hA0, 1);
        @(posedge sck);
        @(negedge clk);
        sleep = 1'b1;
        repeat (100) @(negedge clk);
        chk("R9", "second byte held", int'(elem_cnt), 1);
        chk("R9", "first byte done", exp_tx.size(), 1);
        sleep = 1'b0;
        drain();
        take("R9"); take("R9");

        // R10 disable mid-byte
        chk("R3", "ovf sticky", int'(ovf), 1);
        set_div(1, 0);
        put(8'h96, 1); put(8'h69, 1);
        repeat (3) @(posedge sck);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R10", "sck", int'(sck), 0);
        chk("R10", "elem_cnt", int'(elem_cnt), 0);
        chk("R10", "rx_avail", int'(rx_avail), 0);
        chk("R10", "ovf cleared", int'(ovf), 0);
        exp_tx.delete(); exp_rx.delete(); slv_q.delete();
        mon_idx = 0;
        put(8'h42, 0);
        chk("R10", "write while disabled", int'(elem_cnt), 0);
        en = 1'b1;
        put(8'hC3, 1);
        drain();
        take("R10");

        done = 1;
        summary();
        $finish;
    end
endmodule